// File: doc/BRIEF.md
# Two-wire slave register interface

This block is a slave-only register-access engine for a two-wire serial bus of the SMBus-compatible kind. Its SCL and SDA inputs arrive already synchronized and filtered. It pulls SDA low through an open-drain enable and never drives SCL. Its 7-bit bus address comes from a two-bit address-select input, which is read again at every START condition.

The engine keeps an 8-bit register pointer. The first byte after a write-direction address byte always loads the pointer. The next two bytes write the selected 16-bit register, high byte first. A read-direction transfer returns the register the pointer selects, high byte first, and leaves the pointer unchanged, so the same register can be read again without a new pointer byte. The register file holds these registers:

- 00h: a read/write control word.
- 01h: a read-only identification word.
- 16h, 17h, 18h: three signed 8-bit correction values.

A separate timer watches each bus line. If either line stays low for the timeout period, the engine returns to idle and lets go of SDA.

Top module: `twi_reg_slave`

## Requirements
- R1: With `addr_sel_i` = 00, 01, 10, 11 the slave answers to 7-bit address 5Ch, 5Dh, 5Eh, 5Fh. The slave acknowledges a matching address byte by holding SDA low during the ninth clock. It does not acknowledge any other address, and it ignores the rest of that transfer until the next START.
- R2: `addr_sel_i` is sampled at each START condition. A change in the middle of a transfer has no effect until the next START.
- R3: The first byte after an address byte whose direction bit (bit 0) is 0 loads the register pointer. The pointer resets to 00h.
- R4: In a write, the two bytes after the pointer byte are acknowledged and go to the selected register, most significant byte first. A third data byte is not acknowledged and is discarded. A write that ends after only one data byte leaves the register unchanged.
- R5: A read (direction bit 1) returns the register selected by the last pointer byte, MSB first and then LSB. The pointer is kept, so repeated reads return the same register.
- R6: When the master does not acknowledge a data byte, the slave releases SDA and drives nothing more until the next START.
- R7: A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. A repeated START aborts a transfer in progress and begins address decoding again. After reset the slave does not drive SDA.
- R8: If SCL or SDA stays low for `CLK_KHZ*TIMEOUT_MS` clock cycles, the engine returns to idle and releases SDA. It does not acknowledge again until a new START.
- R9: The register map is as follows:
  - 00h: read/write, reset value `CFG_RST`.
  - 01h: read-only, returns `ID_WORD`.
  - 16h, 17h, 18h: each holds an 8-bit signed value, reset 00h. The value is written from the MSB byte and read back as {value, 00h}.
  - Writes to read-only or unimplemented pointers are acknowledged and discarded.
  - Reads of unimplemented pointers return 0000h.
- R10: The SDA drive changes only while SCL is low. The change takes effect on the clock edge at which the SCL falling edge is first sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level |
| addr_sel_i | input | 2 | Address-select level, chooses the low two address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
The timeout and the acknowledge drive can fall in the same period. The slave is pulling SDA low for an acknowledge while the master holds SCL low. So the stuck-line timer runs out while the byte engine still owns the data line. The bench provokes this by stopping the clock right after the eighth address bit. It checks that the acknowledge is still driven shortly before the limit and released shortly after it. It then checks that clocking a full byte with no new START brings no acknowledge, and that a fresh transfer is answered normally.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam logic [4:0] ADDR_HI     = 5'b10111;
  localparam logic [7:0] PTR_CFG     = 8'h00;
  localparam logic [7:0] PTR_ID      = 8'h01;
  localparam logic [7:0] PTR_NF_BASE = 8'h16;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_PTR, ST_WMSB, ST_WLSB,
    ST_RSTART, ST_RMSB, ST_RLSB, ST_DONE
  } twi_state_e;

  function automatic logic [6:0] dev_addr(input logic [1:0] sel);
    return {ADDR_HI, sel};
  endfunction
endpackage

// File: rtl/twi_bus_cond.sv
module twi_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

  // R7: a bus condition is never seen together with a clock edge
  assert_cond_no_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o || stop_o) |-> !(scl_rise_o || scl_fall_o));
endmodule

// File: rtl/twi_stuck_timer.sv
module twi_stuck_timer #(
  parameter int unsigned LIMIT = 5600000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic to_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM    = CW'(LIMIT);
  localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (line_i)         cnt_q <= '0;
    else if (cnt_q != LIM)   cnt_q <= cnt_q + 1'b1;
  end

  assign to_o = !line_i && (cnt_q == LIM_M1);

  assert_to_after_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_o |-> $past(!line_i));
endmodule

// File: rtl/twi_regfile.sv
module twi_regfile
  import twi_pkg::*;
#(
  parameter logic [15:0] CFG_RST  = 16'h0000,
  parameter logic [15:0] ID_WORD  = 16'h0000,
  parameter int unsigned NF_COUNT = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [7:0]  ptr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o
);
  logic [15:0] cfg_q;
  logic [7:0]  nf_w [NF_COUNT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cfg_q <= CFG_RST;
    else if (we_i && ptr_i == PTR_CFG)  cfg_q <= wdata_i;
  end

  for (genvar g = 0; g < NF_COUNT; g++) begin : g_nf
    localparam logic [7:0] MY_PTR = PTR_NF_BASE + 8'(g);
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      q <= 8'h00;
      else if (we_i && ptr_i == MY_PTR) q <= wdata_i[15:8];
    end
    assign nf_w[g] = q;

    assert_nf_low_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ptr_i == MY_PTR) |-> (rdata_o[7:0] == 8'h00));
  end

  always_comb begin
    rdata_o = 16'h0000;
    if (ptr_i == PTR_CFG) rdata_o = cfg_q;
    if (ptr_i == PTR_ID)  rdata_o = ID_WORD;
    for (int i = 0; i < NF_COUNT; i++)
      if (ptr_i == PTR_NF_BASE + 8'(i)) rdata_o = {nf_w[i], 8'h00};
  end

  assert_cfg_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ptr_i == PTR_CFG) |=> (ptr_i != PTR_CFG || rdata_o == $past(wdata_i)));
  assert_id_fixed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_i == PTR_ID) |-> (rdata_o == ID_WORD));
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
  import twi_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 200000,
  parameter int unsigned TIMEOUT_MS = 28,
  parameter logic [15:0] CFG_RST    = 16'h0000,
  parameter logic [15:0] ID_WORD    = 16'h5131,
  parameter int unsigned NF_COUNT   = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_sel_i,
  output logic       sda_oe_o
);
  localparam int unsigned TO_CYC = CLK_KHZ * TIMEOUT_MS;

  logic scl_rise, scl_fall, start, stop, to_hit;
  logic [1:0] lines, to_vec;

  twi_state_e  state_q;
  logic [3:0]  bit_cnt_q;
  logic [7:0]  rx_q, ptr_q, msb_q;
  logic [6:0]  tx_q, my_addr_q;
  logic        oe_q, mack_q, we;
  logic [15:0] rdata;

  twi_bus_cond u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop)
  );

  assign lines = {scl_i, sda_i};
  for (genvar g = 0; g < 2; g++) begin : g_to
    twi_stuck_timer #(.LIMIT(TO_CYC)) u_tmr (
      .clk_i, .rst_ni, .line_i(lines[g]), .to_o(to_vec[g])
    );
  end
  assign to_hit = |to_vec;

  assign we = scl_fall && bit_cnt_q == 4'd8 && state_q == ST_WLSB;

  twi_regfile #(.CFG_RST(CFG_RST), .ID_WORD(ID_WORD), .NF_COUNT(NF_COUNT)) u_rf (
    .clk_i, .rst_ni, .we_i(we), .ptr_i(ptr_q), .wdata_i({msb_q, rx_q}), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= PTR_CFG;
      msb_q     <= '0;
      oe_q      <= 1'b0;
      mack_q    <= 1'b0;
      my_addr_q <= '0;
    end else if (to_hit) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (start) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
      my_addr_q <= dev_addr(addr_sel_i);
    end else if (stop) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (scl_rise) begin
        if (bit_cnt_q < 4'd8) rx_q   <= {rx_q[6:0], sda_i};
        else                  mack_q <= ~sda_i;
        if (bit_cnt_q != 4'd9) bit_cnt_q <= bit_cnt_q + 1'b1;
      end
      if (scl_fall) begin
        if (bit_cnt_q == 4'd8) begin
          // byte done: ack slot for receive, release for master ack on transmit
          unique case (state_q)
            ST_ADDR: begin
              if (rx_q[7:1] == my_addr_q) begin
                oe_q    <= 1'b1;
                state_q <= rx_q[0] ? ST_RSTART : ST_PTR;
              end else begin
                state_q <= ST_IDLE;
              end
            end
            ST_PTR:  begin ptr_q <= rx_q; oe_q <= 1'b1; state_q <= ST_WMSB; end
            ST_WMSB: begin msb_q <= rx_q; oe_q <= 1'b1; state_q <= ST_WLSB; end
            ST_WLSB: begin oe_q <= 1'b1; state_q <= ST_DONE; end
            default: oe_q <= 1'b0;
          endcase
        end else if (bit_cnt_q == 4'd9) begin
          bit_cnt_q <= '0;
          unique case (state_q)
            ST_RSTART: begin
              tx_q <= rdata[14:8]; oe_q <= ~rdata[15]; state_q <= ST_RMSB;
            end
            ST_RMSB: begin
              if (mack_q) begin
                tx_q <= rdata[6:0]; oe_q <= ~rdata[7]; state_q <= ST_RLSB;
              end else begin
                oe_q <= 1'b0; state_q <= ST_DONE;
              end
            end
            default: begin
              oe_q <= 1'b0;
              if (state_q == ST_RLSB) state_q <= ST_DONE;
            end
          endcase
        end else if (bit_cnt_q != 4'd0 &&
                     (state_q == ST_RMSB || state_q == ST_RLSB)) begin
          oe_q <= ~tx_q[6];
          tx_q <= {tx_q[5:0], 1'b0};
        end
      end
    end
  end

  assign sda_oe_o = oe_q;

  assert_drive_on_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> !scl_i);
  assert_timeout_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_hit |=> (state_q == ST_IDLE && !oe_q));
  assert_ack_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && (state_q == ST_PTR || state_q == ST_WMSB || state_q == ST_WLSB ||
              state_q == ST_DONE)) |-> (bit_cnt_q == 4'd8 || bit_cnt_q == 4'd9));
  assert_ptr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RSTART || state_q == ST_RMSB || state_q == ST_RLSB) |=> $stable(ptr_q));
  assert_stop_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && !to_hit) |=> (state_q == ST_IDLE && !oe_q));
endmodule

// File: tb/twi_reg_slave_tb.sv
module twi_reg_slave_tb;
  localparam int H = 8;
  localparam int TO_CYC = 20 * 28;
  localparam logic [15:0] CFG_RST = 16'hA5C3;
  localparam logic [15:0] ID_WORD = 16'h7E21;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] sel = 2'b00;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  int nchk = 0, nfail = 0, viol = 0;
  logic [15:0] m_cfg = CFG_RST;
  logic [7:0]  m_nf [3] = '{8'h00, 8'h00, 8'h00};

  always #2.5 clk = ~clk;

  twi_reg_slave #(.CLK_KHZ(20), .TIMEOUT_MS(28), .CFG_RST(CFG_RST), .ID_WORD(ID_WORD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel_i(sel), .sda_oe_o(sda_oe)
  );

  // R10 monitor: SDA drive must not change at an edge where SCL was high
  logic scl_at_pos = 1'b1, oe_prev = 1'b0;
  always @(posedge clk) scl_at_pos <= scl_m;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_at_pos) viol++;
    oe_prev = sda_oe;
  end

  function automatic logic [6:0] addr_of(input logic [1:0] s);
    return {5'b10111, s};
  endfunction

  function automatic logic [15:0] exp_read(input logic [7:0] p);
    case (p)
      8'h00: return m_cfg;
      8'h01: return ID_WORD;
      8'h16: return {m_nf[0], 8'h00};
      8'h17: return {m_nf[1], 8'h00};
      8'h18: return {m_nf[2], 8'h00};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic void model_write(input logic [7:0] p, input logic [15:0] d);
    case (p)
      8'h00: m_cfg = d;
      8'h16: m_nf[0] = d[15:8];
      8'h17: m_nf[1] = d[15:8];
      8'h18: m_nf[2] = d[15:8];
      default: ;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(2); sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic send_bit(input logic b);
    tick(2); sda_m = b; tick(H - 2); scl_m = 1'b1; tick(H); scl_m = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    tick(2); sda_m = 1'b1; tick(H - 2); scl_m = 1'b1; tick(H / 2); b = sda_bus;
    tick(H / 2); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
    send_bit(~mack);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] p, input logic [15:0] d,
                          output logic [3:0] acks);
    acks = '0;
    bus_start();
    send_byte({a, 1'b0}, acks[3]);
    if (acks[3]) begin
      send_byte(p, acks[2]);
      send_byte(d[15:8], acks[1]);
      send_byte(d[7:0], acks[0]);
    end
    bus_stop();
  endtask

  task automatic set_ptr(input logic [6:0] a, input logic [7:0] p, output logic [1:0] acks);
    acks = '0;
    bus_start();
    send_byte({a, 1'b0}, acks[1]);
    if (acks[1]) send_byte(p, acks[0]);
    bus_stop();
  endtask

  task automatic do_read(input logic [6:0] a, output logic [15:0] d, output logic ak);
    logic [7:0] hi, lo;
    d = 16'h0000;
    bus_start();
    send_byte({a, 1'b1}, ak);
    if (ak) begin
      recv_byte(hi, 1'b1);
      recv_byte(lo, 1'b0);
      d = {hi, lo};
    end
    bus_stop();
  endtask

  task automatic report();
    if (viol != 0) begin
      nfail++;
      $display("FAIL R10 actual=%0d expected=0 drive changes while SCL high", viol);
    end
    nchk++;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    logic [15:0] rd;
    logic ak;
    logic [3:0] a4;
    logic [1:0] a2;
    logic [7:0] b8;
    int unsigned seed;

    seed = $urandom(32'd1234);
    tick(4);
    rst_n = 1'b1;
    tick(5);
    chk("R7 reset no drive", {31'd0, sda_oe}, 32'd0);

    // R3: pointer resets to 00h
    do_read(addr_of(2'b00), rd, ak);
    chk("R3 read ack", {31'd0, ak}, 32'd1);
    chk("R3 reset pointer", {16'd0, rd}, {16'd0, CFG_RST});

    // R1: address decode for every select value
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      set_ptr(addr_of(2'(s)), 8'h00, a2);
      chk("R1 own address ack", {30'd0, a2}, 32'd3);
      set_ptr(addr_of(2'(s) ^ 2'b01), 8'h00, a2);
      chk("R1 other address nack", {30'd0, a2}, 32'd0);
    end

    // R4/R5: write and read back, repeated reads keep pointer
    sel = 2'b10;
    do_write(addr_of(2'b10), 8'h00, 16'h1234, a4);
    chk("R4 write acks", {28'd0, a4}, 32'hF);
    model_write(8'h00, 16'h1234);
    do_read(addr_of(2'b10), rd, ak);
    chk("R5 read back", {16'd0, rd}, 32'h1234);
    do_read(addr_of(2'b10), rd, ak);
    chk("R5 repeated read", {16'd0, rd}, 32'h1234);

    // R9: read-only, correction values, unimplemented
    do_write(addr_of(2'b10), 8'h01, 16'hBEEF, a4);
    chk("R9 ro write acked", {28'd0, a4}, 32'hF);
    do_read(addr_of(2'b10), rd, ak);
    chk("R9 ro unchanged", {16'd0, rd}, {16'd0, ID_WORD});
    do_write(addr_of(2'b10), 8'h17, 16'h8055, a4);
    model_write(8'h17, 16'h8055);
    do_read(addr_of(2'b10), rd, ak);
    chk("R9 nf17 value", {16'd0, rd}, 32'h8000);
    set_ptr(addr_of(2'b10), 8'h16, a2);
    do_read(addr_of(2'b10), rd, ak);
    chk("R9 nf16 reset", {16'd0, rd}, 32'h0000);
    do_write(addr_of(2'b10), 8'h18, 16'h7F01, a4);
    model_write(8'h18, 16'h7F01);
    do_read(addr_of(2'b10), rd, ak);
    chk("R9 nf18 value", {16'd0, rd}, 32'h7F00);
    do_write(addr_of(2'b10), 8'h40, 16'hAAAA, a4);
    chk("R9 unimpl write acked", {28'd0, a4}, 32'hF);
    do_read(addr_of(2'b10), rd, ak);
    chk("R9 unimpl read zero", {16'd0, rd}, 32'h0000);

    // R4: third data byte is not acknowledged
    bus_start();
    send_byte({addr_of(2'b10), 1'b0}, ak);
    send_byte(8'h00, ak);
    send_byte(8'h11, ak);
    send_byte(8'h22, ak);
    send_byte(8'h33, ak);
    chk("R4 third byte nack", {31'd0, ak}, 32'd0);
    bus_stop();
    model_write(8'h00, 16'h1122);
    do_read(addr_of(2'b10), rd, ak);
    chk("R4 extra byte discarded", {16'd0, rd}, 32'h1122);

    // R4: one data byte then STOP leaves the register unchanged
    bus_start();
    send_byte({addr_of(2'b10), 1'b0}, ak);
    send_byte(8'h00, ak);
    send_byte(8'h99, ak);
    bus_stop();
    do_read(addr_of(2'b10), rd, ak);
    chk("R4 half write ignored", {16'd0, rd}, 32'h1122);

    // R6: master NACK after MSB, slave drives no more
    bus_start();
    send_byte({addr_of(2'b10), 1'b1}, ak);
    recv_byte(b8, 1'b0);
    chk("R6 msb value", {24'd0, b8}, 32'h11);
    recv_byte(b8, 1'b0);
    chk("R6 released after nack", {24'd0, b8}, 32'hFF);
    bus_stop();

    // R2: select change mid-transfer takes effect at next START
    sel = 2'b00;
    bus_start();
    send_byte({addr_of(2'b00), 1'b0}, ak);
    sel = 2'b01;
    send_byte(8'h00, ak);
    chk("R2 mid change ignored", {31'd0, ak}, 32'd1);
    send_byte(8'h56, ak);
    send_byte(8'h78, ak);
    bus_stop();
    model_write(8'h00, 16'h5678);
    do_read(addr_of(2'b00), rd, ak);
    chk("R2 old address now nack", {31'd0, ak}, 32'd0);
    do_read(addr_of(2'b01), rd, ak);
    chk("R2 new address data", {16'd0, rd}, 32'h5678);

    // R7: repeated START aborts write, pointer already updated
    bus_start();
    send_byte({addr_of(2'b01), 1'b0}, ak);
    send_byte(8'h17, ak);
    send_byte(8'hDE, ak);
    bus_start();
    send_byte({addr_of(2'b01), 1'b1}, ak);
    recv_byte(b8, 1'b1);
    rd[15:8] = b8;
    recv_byte(b8, 1'b0);
    rd[7:0] = b8;
    bus_stop();
    chk("R7 restart aborts write", {16'd0, rd}, 32'h8000);

    // R8: SCL held low during the acknowledge slot
    sel = 2'b00;
    bus_start();
    for (int i = 7; i >= 1; i--) send_bit(addr_of(2'b00)[i - 1]);
    send_bit(1'b0);
    tick(4);
    chk("R8 ack driven", {31'd0, sda_oe}, 32'd1);
    tick(TO_CYC - 120);
    chk("R8 not before limit", {31'd0, sda_oe}, 32'd1);
    tick(200);
    chk("R8 released after limit", {31'd0, sda_oe}, 32'd0);
    send_byte({addr_of(2'b00), 1'b0}, ak);
    chk("R8 idle until start", {31'd0, ak}, 32'd0);
    bus_stop();
    do_read(addr_of(2'b00), rd, ak);
    chk("R8 recovers", {16'd0, rd}, 32'h8000);

    // random mix against the model
    for (int t = 0; t < 40; t++) begin
      logic [1:0] s, tgt;
      logic [7:0] p;
      logic [15:0] d;
      logic wrong;
      s = 2'($urandom % 4);
      sel = s;
      wrong = ($urandom % 6) == 0;
      tgt = wrong ? s ^ 2'b10 : s;
      case ($urandom % 6)
        0: p = 8'h00;
        1: p = 8'h01;
        2: p = 8'h16;
        3: p = 8'h17;
        4: p = 8'h18;
        default: p = 8'h20 + 8'($urandom % 64);
      endcase
      d = 16'($urandom);
      if ($urandom % 2 == 0) begin
        do_write(addr_of(tgt), p, d, a4);
        chk(wrong ? "R1 random nack" : "R4 random write acks", {28'd0, a4},
            wrong ? 32'h0 : 32'hF);
        if (!wrong) model_write(p, d);
      end else begin
        set_ptr(addr_of(tgt), p, a2);
        chk(wrong ? "R1 random nack" : "R3 random ptr acks", {30'd0, a2},
            wrong ? 32'h0 : 32'h3);
        if (!wrong) begin
          do_read(addr_of(tgt), rd, ak);
          chk("R5 random read", {16'd0, rd}, {16'd0, exp_read(p)});
        end
      end
    end

    tick(20);
    report();
  end
endmodule